// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Masking

This block collects up to 63 peripheral interrupt request lines and presents a single winning request to the processor. Each source owns a small configuration register that assigns it an interrupt level (1 to 7) and a rank within that level (0 to 7). Level 0 means the source is switched off. A per-source mask bit, held in two 32-bit halves, blocks a source while it is set. The live request lines can be read back as two 32-bit pending words.

Every cycle a comparison tree looks at all sources that are requesting, unmasked and configured with a non-zero level. It selects the highest level, then the highest rank within that level, and then the lowest source number. The result is registered onto `irq_level` and `irq_src`. The configuration registers for sources 1 to 7 are fixed at their disabled reset value.

When the processor takes the interrupt it raises `ack` for one cycle. `ack_src` then captures the source that was being presented in that cycle. The register port is a plain single-cycle port: a write takes effect at the clock edge where `reg_we` is high, and a read returns data combinationally with no back-pressure. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Writing address 64+n (n = 8..63) stores bits [5:3] as the level and bits [2:0] as the rank of source n. Reading that address returns them in the same bit positions, with all other bits zero. After reset every configuration reads zero.
- R2: The configuration of sources 1..7 (addresses 65..71) ignores writes and always reads zero.
- R3: A source whose level is 0 is never presented, whatever its request and mask bits are.
- R4: Address 0 returns the requests of sources 1..31 in bits 31:1, with bit 0 reading zero. Address 1 returns the requests of sources 32..63 in bits 31:0. Both follow the live request lines.
- R5: Addresses 2 and 3 are the mask words, using the same bit-per-source layout as R4. Both reset to all ones. A source can win only while its mask bit is 0.
- R6: Among the eligible sources, one with a higher level always beats one with a lower level, whatever their ranks.
- R7: Among eligible sources at the same level, the higher rank wins, even over a lower-numbered source.
- R8: `irq_level` and `irq_src` are registered. They reflect the request, mask and configuration state of the previous clock edge. Both read zero when no source is eligible.
- R9: One edge after a cycle with `ack` high, `ack_src` equals the `irq_src` of that cycle. At all other times `ack_src` holds its value. It resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 63 | Request lines; bit i-1 belongs to source i |
| ack | input | 1 | Processor acknowledge strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_level | output | 3 | Presented interrupt level, 0 when idle |
| irq_src | output | 6 | Presented source number, 0 when idle |
| ack_src | output | 6 | Source number captured at the last acknowledge |

## Verification
The assertions assume that software never gives two enabled sources the same level and rank, because the winner for duplicate pairs is not a defined result. The bench programs sources 8..63 with 56 distinct (level, rank) pairs. When it reassigns one source's pair, it first disables the source that already held that pair. The assertions also assume that `ack` is only sampled as a single-cycle pulse. The bench drives it that way, and it changes requests, masks and configuration only on the falling clock edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W = 3;
  localparam int PRI_W = 3;
  localparam int CFG_W = LVL_W + PRI_W;

  // level sits above rank so that a packed compare ranks level first
  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [PRI_W-1:0] pri;
  } irq_cfg_t;
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SLOT = 64,
  parameter int RO_LAST  = 7,
  localparam int IDX_W   = $clog2(NUM_SLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  irq_cfg_t         wr_cfg,
  output irq_cfg_t         cfg [NUM_SLOT]
);
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    if (g <= RO_LAST) begin : g_fixed
      // slot 0 and the read-only slots stay at the disabled value
      assign cfg[g] = '0;
    end else begin : g_rw
      irq_cfg_t cfg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 cfg_q <= '0;
        else if (wr_en && (wr_idx == IDX_W'(g)))    cfg_q <= wr_cfg;
      end
      assign cfg[g] = cfg_q;
    end
  end
endmodule

// File: rtl/irqc_src_regs.sv
module irqc_src_regs #(
  parameter int NUM_SLOT = 64,
  parameter int HALF_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SLOT-1:1] src_req,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [NUM_SLOT-1:0] pend_vec,
  output logic [NUM_SLOT-1:0] mask_vec
);
  logic [NUM_SLOT-1:1] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      for (int i = 1; i < NUM_SLOT; i++) begin
        if (i < HALF_W) begin
          if (wr_lo) mask_q[i] <= wdata[i % HALF_W];
        end else begin
          if (wr_hi) mask_q[i] <= wdata[i % HALF_W];
        end
      end
    end
  end

  // slot 0 has no source: always masked, never pending
  assign mask_vec = {mask_q, 1'b1};
  assign pend_vec = {src_req, 1'b0};
endmodule

// File: rtl/irqc_arb_tree.sv
module irqc_arb_tree
  import irqc_pkg::*;
#(
  parameter int NUM_SLOT = 64,
  localparam int IDX_W   = $clog2(NUM_SLOT),
  localparam int N_LEAF  = 1 << IDX_W,
  localparam int N_NODE  = 2 * N_LEAF - 1
) (
  input  logic [NUM_SLOT-1:0] pend_vec,
  input  logic [NUM_SLOT-1:0] mask_vec,
  input  irq_cfg_t            cfg [NUM_SLOT],
  output logic                win_vld,
  output logic [LVL_W-1:0]    win_lvl,
  output logic [IDX_W-1:0]    win_idx
);
  logic             nd_vld [N_NODE];
  irq_cfg_t         nd_key [N_NODE];
  logic [IDX_W-1:0] nd_idx [N_NODE];

  // leaves in source order, so a left child always has the lower number
  for (genvar i = 0; i < N_LEAF; i++) begin : g_leaf
    if (i < NUM_SLOT) begin : g_real
      assign nd_vld[N_LEAF-1+i] = pend_vec[i] && !mask_vec[i] && (cfg[i].lvl != '0);
      assign nd_key[N_LEAF-1+i] = cfg[i];
    end else begin : g_pad
      assign nd_vld[N_LEAF-1+i] = 1'b0;
      assign nd_key[N_LEAF-1+i] = '0;
    end
    assign nd_idx[N_LEAF-1+i] = IDX_W'(i);
  end

  for (genvar n = 0; n < N_LEAF - 1; n++) begin : g_node
    logic take_r;
    // right child wins only with a strictly larger key: ties keep the lower index
    assign take_r = nd_vld[2*n+2] && (!nd_vld[2*n+1] || (nd_key[2*n+2] > nd_key[2*n+1]));
    assign nd_vld[n] = nd_vld[2*n+1] || nd_vld[2*n+2];
    assign nd_key[n] = take_r ? nd_key[2*n+2] : nd_key[2*n+1];
    assign nd_idx[n] = take_r ? nd_idx[2*n+2] : nd_idx[2*n+1];
  end

  assign win_vld = nd_vld[0];
  assign win_lvl = nd_key[0].lvl;
  assign win_idx = nd_idx[0];
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int RO_LAST = 7,
  localparam int NUM_SLOT = NUM_SRC + 1,
  localparam int IDX_W    = $clog2(NUM_SLOT),
  localparam int HALF_W   = 32,
  localparam int ADDR_W   = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               ack,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [HALF_W-1:0]  reg_wdata,
  output logic [HALF_W-1:0]  reg_rdata,
  output logic [LVL_W-1:0]   irq_level,
  output logic [IDX_W-1:0]   irq_src,
  output logic [IDX_W-1:0]   ack_src
);
  irq_cfg_t            cfg [NUM_SLOT];
  logic [NUM_SLOT-1:0] pend_vec;
  logic [NUM_SLOT-1:0] mask_vec;
  logic                cfg_sel;
  logic                win_vld;
  logic [LVL_W-1:0]    win_lvl;
  logic [IDX_W-1:0]    win_idx;
  logic [2*HALF_W-1:0] pend_w;
  logic [2*HALF_W-1:0] mask_w;

  // upper half of the address space maps the configuration registers
  assign cfg_sel = reg_addr[ADDR_W-1];

  irqc_cfg_regs #(.NUM_SLOT(NUM_SLOT), .RO_LAST(RO_LAST)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_we && cfg_sel),
    .wr_idx (reg_addr[IDX_W-1:0]),
    .wr_cfg (irq_cfg_t'(reg_wdata[CFG_W-1:0])),
    .cfg    (cfg)
  );

  irqc_src_regs #(.NUM_SLOT(NUM_SLOT), .HALF_W(HALF_W)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .wr_lo    (reg_we && (reg_addr == ADDR_W'(2))),
    .wr_hi    (reg_we && (reg_addr == ADDR_W'(3))),
    .wdata    (reg_wdata),
    .pend_vec (pend_vec),
    .mask_vec (mask_vec)
  );

  irqc_arb_tree #(.NUM_SLOT(NUM_SLOT)) u_arb (
    .pend_vec (pend_vec),
    .mask_vec (mask_vec),
    .cfg      (cfg),
    .win_vld  (win_vld),
    .win_lvl  (win_lvl),
    .win_idx  (win_idx)
  );

  assign pend_w = (2*HALF_W)'(pend_vec);
  assign mask_w = (2*HALF_W)'(mask_vec);

  always_comb begin
    reg_rdata = '0;
    if (cfg_sel) begin
      if (int'(reg_addr[IDX_W-1:0]) < NUM_SLOT)
        reg_rdata = HALF_W'(cfg[reg_addr[IDX_W-1:0]]);
    end else begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata = pend_w[HALF_W-1:0];
        2'd1:    reg_rdata = pend_w[2*HALF_W-1:HALF_W];
        2'd2:    reg_rdata = mask_w[HALF_W-1:0];
        default: reg_rdata = mask_w[2*HALF_W-1:HALF_W];
      endcase
      if (reg_addr[ADDR_W-2:2] != '0) reg_rdata = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= '0;
      irq_src   <= '0;
      ack_src   <= '0;
    end else begin
      irq_level <= win_vld ? win_lvl : '0;
      irq_src   <= win_vld ? win_idx : '0;
      if (ack) ack_src <= irq_src;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_SLOT = 64,
  parameter int RO_LAST  = 7,
  localparam int IDX_W   = $clog2(NUM_SLOT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_SLOT-2:0] src_req,
  input logic                ack,
  input logic [LVL_W-1:0]    irq_level,
  input logic [IDX_W-1:0]    irq_src,
  input logic [IDX_W-1:0]    ack_src,
  input logic [NUM_SLOT-1:0] mask_vec,
  input irq_cfg_t            cfg [NUM_SLOT]
);
  logic [NUM_SLOT-1:0] mask_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_prev <= '1;
    else        mask_prev <= mask_vec;
  end

  // R2: the fixed slots never hold anything but the disabled value
  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 1; i <= RO_LAST; i++)
        a_r2_fixed_cfg: assert (cfg[i] == '0) else $error("R2 slot %0d changed", i);
    end
  end

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == '0) |=> (irq_level == '0 && irq_src == '0));

  a_r8_level_src_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) == (irq_src == '0));

  a_r3_fixed_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (int'(irq_src) > RO_LAST));

  a_r5_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> !mask_prev[irq_src]);

  a_r9_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (ack_src == $past(irq_src)));

  a_r9_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(ack_src));
endmodule

bind irq_prio_ctrl irqc_checker #(.NUM_SLOT(NUM_SLOT), .RO_LAST(RO_LAST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_req   (src_req),
  .ack       (ack),
  .irq_level (irq_level),
  .irq_src   (irq_src),
  .ack_src   (ack_src),
  .mask_vec  (mask_vec),
  .cfg       (cfg)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [62:0] src_req = '0;
  logic        ack = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_level;
  logic [5:0]  irq_src;
  logic [5:0]  ack_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .ack(ack),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_level(irq_level), .irq_src(irq_src),
    .ack_src(ack_src)
  );

  typedef struct packed {
    logic [63:0] req;
    logic [63:0] mask;
    logic [2:0]  lvl;
    logic [5:0]  src;
  } vec_t;

  // source n (8..63) is programmed to level (n-8)/8+1, rank (n-8)%8
  localparam vec_t VECS [13] = '{
    '{64'h0,                   64'h0,                   3'd0, 6'd0 },  // R8 idle
    '{64'h100,                 64'h0,                   3'd1, 6'd8 },  // R6
    '{64'h0010_0100,           64'h0,                   3'd2, 6'd20},  // R6
    '{64'h8000_0000_0010_0000, 64'h8000_0000_0000_0000, 3'd2, 6'd20},  // R5
    '{64'h8000_0000_0000_0000, 64'h0,                   3'd7, 6'd63},  // R6
    '{64'h0000_0100_0000_0008, 64'h0,                   3'd5, 6'd40},  // R3
    '{64'h8,                   64'h0,                   3'd0, 6'd0 },  // R3
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 6'd0 },  // R5
    '{64'h0000_0006_0000_0000, 64'h0,                   3'd4, 6'd34},  // R7
    '{64'h0000_0001_8000_0000, 64'h0,                   3'd4, 6'd32},  // R6
    '{64'h0300_0000_0000_0000, 64'h0,                   3'd7, 6'd57},  // R7
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   3'd7, 6'd63},  // R6
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FDFF, 3'd1, 6'd9 }   // R5
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R8 reset level", irq_level, 0);
    chk("R8 reset src", irq_src, 0);
    chk("R9 reset ack_src", ack_src, 0);
    rd_chk("R5 mask lo reset", 7'd2, 32'hFFFF_FFFF);
    rd_chk("R5 mask hi reset", 7'd3, 32'hFFFF_FFFF);
    rd_chk("R1 cfg reset", 7'd84, 32'h0);

    // R3: unmasked requests with all levels at reset stay silent
    wr(7'd2, 32'h0); wr(7'd3, 32'h0);
    src_req = '1;
    repeat (2) @(negedge clk);
    chk("R3 reset cfg silent", irq_level, 0);
    src_req = '0;

    for (int n = 8; n < 64; n++)
      wr(7'(64 + n), {26'd0, 3'((n - 8) / 8 + 1), 3'((n - 8) % 8)});
    rd_chk("R1 cfg readback src20", 7'd84, 32'h14);
    rd_chk("R1 cfg readback src63", 7'd127, 32'h3F);

    // R2: fixed slot ignores writes
    wr(7'd69, 32'h3F);
    rd_chk("R2 fixed cfg readback", 7'd69, 32'h0);
    src_req = 63'(64'h20 >> 1);
    repeat (2) @(negedge clk);
    chk("R2 fixed source silent", irq_level, 0);

    for (int v = 0; v < 13; v++) begin
      wr(7'd2, VECS[v].mask[31:0]);
      wr(7'd3, VECS[v].mask[63:32]);
      src_req = VECS[v].req[63:1];
      repeat (2) @(negedge clk);
      chk($sformatf("R6 R7 R5 vec%0d level", v), irq_level, VECS[v].lvl);
      chk($sformatf("R6 R7 R5 vec%0d src", v), irq_src, VECS[v].src);
      rd_chk($sformatf("R4 vec%0d pend lo", v), 7'd0, {VECS[v].req[31:1], 1'b0});
      rd_chk($sformatf("R4 vec%0d pend hi", v), 7'd1, VECS[v].req[63:32]);
    end

    // R7: higher rank at lower level number position beats lower-numbered? give src12 rank 7 at level 3
    wr(7'd2, 32'h0); wr(7'd3, 32'h0);
    wr(7'd95, 32'h0);            // disable source 31 (it held level 3 rank 7)
    wr(7'd76, 32'h1F);           // source 12: level 3 rank 7
    src_req = 63'(((64'd1 << 12) | (64'd1 << 30) | (64'd1 << 31)) >> 1);
    repeat (2) @(negedge clk);
    chk("R7 rank beats index level", irq_level, 3);
    chk("R7 rank beats index src", irq_src, 12);

    // R9: acknowledge capture and hold
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9 ack capture", ack_src, 12);
    src_req = 63'((64'd1 << 30) >> 1);
    repeat (2) @(negedge clk);
    chk("R9 new winner", irq_src, 30);
    chk("R9 ack hold", ack_src, 12);

    // R8: one-edge latency from request to output
    src_req = 63'((64'd1 << 63) >> 1);
    @(negedge clk);
    chk("R8 latency level", irq_level, 7);
    chk("R8 latency src", irq_src, 63);
    src_req = '0;
    @(negedge clk);
    chk("R8 drop to idle", irq_level, 0);
    chk("R8 drop src", irq_src, 0);

    finish_run();
  end
endmodule